// File: doc/BRIEF.md
# Dual-Rate NCO Complex Mixer

This block shifts a sampled signal in frequency. It multiplies each incoming sample by the conjugate of a complex exponential, exp(-j*theta). The angle theta comes from a numerically controlled oscillator: a 32-bit phase accumulator steps by a programmable increment for every accepted input beat. A carry input adds one LSB to the step, so an external accumulator can extend the tuning resolution. A signed offset port is added to the increment, which lets a tracking loop pull the frequency.

There are two modes. In complex mode, each beat carries one I/Q sample and produces one mixed I/Q pair. In real mode, each beat carries two consecutive real samples, even then odd. The even sample is mixed at the current phase and the odd sample at that phase plus one increment. Each beat then yields two complex pairs, and the accumulator moves by two increments per beat. The mode is sampled with each beat, so the two modes may be interleaved.

Both stream sides use valid/ready handshakes. A beat is taken when `s_valid` and `s_ready` are both high at a rising edge. `s_ready` is high whenever the output register is empty or the consumer is taking its contents. While `m_valid` is high and `m_ready` is low, the whole pipeline freezes, no new beat is taken, and every `m_*` output holds its value. Control inputs (`real_mode`, `freq_word`, `freq_adj`, `carry_in`) are sampled together with each accepted beat.

Top module: `nco_mixer`

## Requirements
- R1: In complex mode (`real_mode`=0), with s_a=I, s_b=Q and oscillator values c, s, the outputs are m_i0 = rnd(I*c + Q*s) and m_q0 = rnd(Q*c - I*s). Here rnd(x) = floor((x + 16384) / 32768), clipped to the signed 16-bit range.
- R2: In real mode (`real_mode`=1), with s_a=even sample e and s_b=odd sample o, the outputs are m_i0 = rnd(e*c0), m_q0 = rnd(-e*s0), m_i1 = rnd(o*c1), m_q1 = rnd(-o*s1), and m_pair=1. Here (c0,s0) belong to phase P and (c1,s1) to phase P+inc.
- R3: The first beat after reset is mixed at phase 0. After each accepted beat the phase advances by inc = freq_word + freq_adj (mod 2^32) in complex mode, or by 2*inc in real mode.
- R4: When `carry_in`=1 on an accepted beat, the phase used by the next beat is one LSB larger than it would otherwise be.
- R5: The oscillator uses only the top 6 phase bits (bits 31:26), and the lower bits are ignored. Phase 0 gives c=32767, s=0. Phase 0x20000000 (45 deg) gives c=s=23170. Further multiples of 45 deg follow by quadrant symmetry: 90 deg gives c=0, s=32767; 180 deg gives c=-32767, s=0; 270 deg gives c=0, s=-32767.
- R6: With `m_ready` held high, a beat accepted at rising edge k appears on the outputs, with `m_valid`=1, right after rising edge k+3.
- R7: While m_valid=1 and m_ready=0, s_ready is 0 and all outputs hold. Beats leave in the order they arrived, none lost or repeated, and the phase advances only for accepted beats.
- R8: For a complex-mode beat, m_pair=0 and m_i1 = m_q1 = 0.
- R9: freq_adj is added to freq_word, modulo 2^32, to form the per-sample increment. A negative offset lowers the frequency.
- R10: While rst_n=0, m_valid is 0, s_ready is 1, and the phase accumulator is cleared.
- R11: A mixed result beyond the signed 16-bit range saturates to 32767 or -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| real_mode | input | 1 | 1: beat is an even/odd real pair; 0: beat is one I/Q sample |
| freq_word | input | 32 | Phase increment per sample |
| freq_adj | input | 32 | Signed offset added to the increment (loop correction) |
| carry_in | input | 1 | Adds one LSB to the accumulator on an accepted beat |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Block can take a beat |
| s_a | input | 16 | I sample (complex) or even sample (real), signed |
| s_b | input | 16 | Q sample (complex) or odd sample (real), signed |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Consumer takes the output beat |
| m_pair | output | 1 | 1 when the beat holds two complex pairs (real mode) |
| m_i0 | output | 16 | I of the complex result, or of the even-sample product |
| m_q0 | output | 16 | Q of the complex result, or of the even-sample product |
| m_i1 | output | 16 | I of the odd-sample product (zero in complex mode) |
| m_q1 | output | 16 | Q of the odd-sample product (zero in complex mode) |

## Verification
The assertions check the handshake on every cycle: outputs frozen under a stall, s_ready low while the output is blocked, the odd lane quiet on complex beats, and no valid output during reset. The arithmetic content can only be shown by the bench's scenarios, because it depends on the phase history. This covers the rounding and saturation values, the even/odd phase split, the carry-in and offset effects on tuning, the fixed latency, and in-order delivery under random stalls. For those checks the bench steers the phase onto multiples of 45 degrees, where the oscillator values are known exactly.

// File: rtl/nco_mix_pkg.sv
package nco_mix_pkg;

  // quarter-wave table resolution: 2**QTR_BITS steps per 90 degrees
  localparam int QTR_BITS = 4;
  // oscillator amplitude width (full scale 32767)
  localparam int SIN_W = 16;

  // sin(k * pi / 32) * 32767, k = 0 .. 16
  function automatic logic signed [SIN_W-1:0] qtr_sin(input logic [QTR_BITS:0] k);
    logic signed [SIN_W-1:0] v;
    case (k)
      5'd0:    v = 16'sd0;
      5'd1:    v = 16'sd3212;
      5'd2:    v = 16'sd6393;
      5'd3:    v = 16'sd9512;
      5'd4:    v = 16'sd12539;
      5'd5:    v = 16'sd15446;
      5'd6:    v = 16'sd18204;
      5'd7:    v = 16'sd20787;
      5'd8:    v = 16'sd23170;
      5'd9:    v = 16'sd25329;
      5'd10:   v = 16'sd27245;
      5'd11:   v = 16'sd28898;
      5'd12:   v = 16'sd30273;
      5'd13:   v = 16'sd31356;
      5'd14:   v = 16'sd32137;
      5'd15:   v = 16'sd32609;
      default: v = 16'sd32767;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          real_mode,
  input  logic [PW-1:0] freq_word,
  input  logic [PW-1:0] freq_adj,
  input  logic          carry_in,
  output logic [PW-1:0] ph_even,
  output logic [PW-1:0] ph_odd
);
  logic [PW-1:0] acc;
  logic [PW-1:0] inc;
  logic [PW-1:0] step;

  assign inc  = freq_word + freq_adj;
  // two phases per beat in real mode
  assign step = real_mode ? {inc[PW-2:0], 1'b0} : inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      ph_even <= '0;
      ph_odd  <= '0;
    end else if (adv) begin
      ph_even <= acc;
      ph_odd  <= acc + inc;
      acc     <= acc + step + PW'(carry_in);
    end
  end
endmodule

// File: rtl/nco_sincos.sv
module nco_sincos
  import nco_mix_pkg::*;
#(
  parameter int PW = 32
) (
  input  logic [PW-1:0]            phase,
  output logic signed [SIN_W-1:0]  sin_o,
  output logic signed [SIN_W-1:0]  cos_o
);
  localparam int AB   = QTR_BITS + 2;
  localparam int FULL = 1 << QTR_BITS;

  logic [AB-1:0] a_sin;
  logic [AB-1:0] a_cos;
  logic          unused_lo;

  assign a_sin     = phase[PW-1 -: AB];
  assign a_cos     = a_sin + AB'(FULL);   // cos(x) = sin(x + 90 deg)
  assign unused_lo = ^phase[PW-AB-1:0];

  // quadrant folding: odd quadrants mirror the index, upper half negates
  function automatic logic signed [SIN_W-1:0] fold(input logic [AB-1:0] a);
    logic [QTR_BITS:0]       k;
    logic signed [SIN_W-1:0] m;
    k = a[AB-2] ? (QTR_BITS+1)'(FULL) - {1'b0, a[QTR_BITS-1:0]}
                : {1'b0, a[QTR_BITS-1:0]};
    m = qtr_sin(k);
    return a[AB-1] ? -m : m;
  endfunction

  assign sin_o = fold(a_sin);
  assign cos_o = fold(a_cos);
endmodule

// File: rtl/nco_mix_math.sv
module nco_mix_math #(
  parameter int DW = 16,
  parameter int SW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 mode_in,
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  input  logic signed [SW-1:0] c0,
  input  logic signed [SW-1:0] s0,
  input  logic signed [SW-1:0] c1,
  input  logic signed [SW-1:0] s1,
  output logic                 mode_out,
  output logic signed [DW-1:0] i0,
  output logic signed [DW-1:0] q0,
  output logic signed [DW-1:0] i1,
  output logic signed [DW-1:0] q1
);
  localparam int PRW   = DW + SW;
  localparam int SUMW  = PRW + 1;
  localparam int SHIFT = SW - 1;
  localparam logic signed [SUMW-1:0] RND  = SUMW'(1) <<< (SHIFT - 1);
  localparam logic signed [SUMW-1:0] MAXV = SUMW'((2 ** (DW - 1)) - 1);
  localparam logic signed [SUMW-1:0] MINV = -SUMW'(2 ** (DW - 1));

  logic signed [PRW-1:0] p_ac, p_bs, p_bc, p_as, p_bc1, p_bs1;
  logic                  mode_c;
  logic signed [SUMW-1:0] sum_i, sum_q;

  function automatic logic signed [DW-1:0] rnd_sat(input logic signed [SUMW-1:0] x);
    logic signed [SUMW-1:0] y;
    y = (x + RND) >>> SHIFT;
    if (y > MAXV)      y = MAXV;
    else if (y < MINV) y = MINV;
    return y[DW-1:0];
  endfunction

  // stage C: products
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {p_ac, p_bs, p_bc, p_as, p_bc1, p_bs1} <= '0;
      mode_c <= 1'b0;
    end else if (en) begin
      p_ac   <= a * c0;
      p_bs   <= b * s0;
      p_bc   <= b * c0;
      p_as   <= a * s0;
      p_bc1  <= b * c1;
      p_bs1  <= b * s1;
      mode_c <= mode_in;
    end
  end

  assign sum_i = SUMW'(p_ac) + SUMW'(p_bs);
  assign sum_q = SUMW'(p_bc) - SUMW'(p_as);

  // stage D: combine, round, saturate
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {i0, q0, i1, q1} <= '0;
      mode_out <= 1'b0;
    end else if (en) begin
      mode_out <= mode_c;
      if (mode_c) begin
        i0 <= rnd_sat(SUMW'(p_ac));
        q0 <= rnd_sat(-SUMW'(p_as));
        i1 <= rnd_sat(SUMW'(p_bc1));
        q1 <= rnd_sat(-SUMW'(p_bs1));
      end else begin
        i0 <= rnd_sat(sum_i);
        q0 <= rnd_sat(sum_q);
        i1 <= '0;
        q1 <= '0;
      end
    end
  end
endmodule

// File: rtl/nco_mixer.sv
module nco_mixer
  import nco_mix_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 real_mode,
  input  logic [PW-1:0]        freq_word,
  input  logic [PW-1:0]        freq_adj,
  input  logic                 carry_in,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic signed [DW-1:0] s_a,
  input  logic signed [DW-1:0] s_b,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic                 m_pair,
  output logic signed [DW-1:0] m_i0,
  output logic signed [DW-1:0] m_q0,
  output logic signed [DW-1:0] m_i1,
  output logic signed [DW-1:0] m_q1
);
  localparam int LANES = 2;

  logic en, take;
  logic v_a, v_b, v_c, v_d;
  logic mode_a, mode_b;
  logic signed [DW-1:0] a_a, b_a, a_b, b_b;
  logic [PW-1:0] ph_even, ph_odd;
  logic [PW-1:0] lane_ph [LANES];
  logic signed [SIN_W-1:0] lane_s [LANES];
  logic signed [SIN_W-1:0] lane_c [LANES];
  logic signed [SIN_W-1:0] s_b_r  [LANES];
  logic signed [SIN_W-1:0] c_b_r  [LANES];

  // whole pipeline advances unless the output beat is blocked
  assign en      = !v_d || m_ready;
  assign s_ready = en;
  assign take    = s_valid && en;
  assign m_valid = v_d;

  nco_phase_acc #(.PW(PW)) acc_i (
    .clk(clk), .rst_n(rst_n), .adv(take), .real_mode(real_mode),
    .freq_word(freq_word), .freq_adj(freq_adj), .carry_in(carry_in),
    .ph_even(ph_even), .ph_odd(ph_odd)
  );

  // stage A: capture beat
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_a <= 1'b0; mode_a <= 1'b0; a_a <= '0; b_a <= '0;
    end else if (en) begin
      v_a <= take;
      if (take) begin
        mode_a <= real_mode;
        a_a    <= s_a;
        b_a    <= s_b;
      end
    end
  end

  assign lane_ph[0] = ph_even;
  assign lane_ph[1] = ph_odd;

  // stage B: one oscillator lookup per time lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    nco_sincos #(.PW(PW)) osc_i (
      .phase(lane_ph[g]), .sin_o(lane_s[g]), .cos_o(lane_c[g])
    );
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_b_r[g] <= '0;
        c_b_r[g] <= '0;
      end else if (en) begin
        s_b_r[g] <= lane_s[g];
        c_b_r[g] <= lane_c[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_b <= 1'b0; mode_b <= 1'b0; a_b <= '0; b_b <= '0;
      v_c <= 1'b0; v_d <= 1'b0;
    end else if (en) begin
      v_b    <= v_a;
      mode_b <= mode_a;
      a_b    <= a_a;
      b_b    <= b_a;
      v_c    <= v_b;
      v_d    <= v_c;
    end
  end

  // stages C and D
  nco_mix_math #(.DW(DW), .SW(SIN_W)) math_i (
    .clk(clk), .rst_n(rst_n), .en(en), .mode_in(mode_b),
    .a(a_b), .b(b_b),
    .c0(c_b_r[0]), .s0(s_b_r[0]), .c1(c_b_r[1]), .s1(s_b_r[1]),
    .mode_out(m_pair), .i0(m_i0), .q0(m_q0), .i1(m_i1), .q1(m_q1)
  );
endmodule

// File: rtl/nco_mixer_chk.sv
module nco_mixer_chk #(
  parameter int DW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 s_ready,
  input logic                 m_valid,
  input logic                 m_ready,
  input logic                 m_pair,
  input logic signed [DW-1:0] m_i0,
  input logic signed [DW-1:0] m_q0,
  input logic signed [DW-1:0] m_i1,
  input logic signed [DW-1:0] m_q1
);
  // R10: nothing valid right after a reset cycle
  p_reset_quiet_r10: assert property (@(posedge clk) !rst_n |=> !m_valid);

  // R7: blocked output beat is held unchanged
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_pair) && $stable(m_i0)
      && $stable(m_q0) && $stable(m_i1) && $stable(m_q1)));

  // R7: no input taken while the output is blocked
  p_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready);

  // R8: odd lane silent on complex beats
  p_lane1_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_pair) |-> (m_i1 == '0 && m_q1 == '0));
endmodule

bind nco_mixer nco_mixer_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .m_valid(m_valid),
  .m_ready(m_ready), .m_pair(m_pair), .m_i0(m_i0), .m_q0(m_q0),
  .m_i1(m_i1), .m_q1(m_q1)
);

// File: tb/nco_mixer_tb_top.sv
module nco_mixer_tb_top;
  localparam int DW = 16;
  localparam int QN = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                 rst_n = 1'b0;
  logic                 real_mode = 1'b0;
  logic [31:0]          freq_word = '0;
  logic [31:0]          freq_adj = '0;
  logic                 carry_in = 1'b0;
  logic                 s_valid = 1'b0;
  logic                 s_ready;
  logic signed [DW-1:0] s_a = '0;
  logic signed [DW-1:0] s_b = '0;
  logic                 m_valid;
  logic                 m_ready = 1'b1;
  logic                 m_pair;
  logic signed [DW-1:0] m_i0, m_q0, m_i1, m_q1;

  nco_mixer dut_i (
    .clk(clk), .rst_n(rst_n), .real_mode(real_mode), .freq_word(freq_word),
    .freq_adj(freq_adj), .carry_in(carry_in), .s_valid(s_valid), .s_ready(s_ready),
    .s_a(s_a), .s_b(s_b), .m_valid(m_valid), .m_ready(m_ready), .m_pair(m_pair),
    .m_i0(m_i0), .m_q0(m_q0), .m_i1(m_i1), .m_q1(m_q1)
  );

  int checks = 0, errors = 0, cyc = 0, bp_cnt = 0;
  bit bp_on = 0, lat_on = 0, done = 0;
  logic [31:0] macc;

  int    e_i0 [QN], e_q0 [QN], e_i1 [QN], e_q1 [QN], e_cyc [QN];
  bit    e_ok [QN], e_pair [QN], e_lat [QN];
  string e_tag [QN];
  int    wr = 0, rd = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    bp_cnt  <= bp_cnt + 1;
    m_ready <= !bp_on || (bp_cnt % 3 != 0);
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int rnd(input longint x);
    longint y;
    y = (x + 16384) >>> 15;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return int'(y);
  endfunction

  // exact oscillator values on the 45-degree grid (R5)
  function automatic bit grid(input logic [31:0] ph, output int c, output int s);
    c = 0; s = 0;
    if (ph[28:26] != 3'd0) return 1'b0;
    case (ph[31:29])
      3'd0: begin c = 32767;  s = 0;      end
      3'd1: begin c = 23170;  s = 23170;  end
      3'd2: begin c = 0;      s = 32767;  end
      3'd3: begin c = -23170; s = 23170;  end
      3'd4: begin c = -32767; s = 0;      end
      3'd5: begin c = -23170; s = -23170; end
      3'd6: begin c = 0;      s = -32767; end
      default: begin c = 23170; s = -23170; end
    endcase
    return 1'b1;
  endfunction

  task automatic push_beat(input string tag);
    logic [31:0] inc, pe, po;
    int c0, s0, c1, s1;
    bit k0, k1;
    longint a, b;
    inc = freq_word + freq_adj;
    pe = macc; po = macc + inc;
    k0 = grid(pe, c0, s0);
    k1 = grid(po, c1, s1);
    a = longint'(s_a); b = longint'(s_b);
    if (real_mode) begin
      e_ok[wr] = k0 && k1;
      e_i0[wr] = rnd(a * c0);  e_q0[wr] = rnd(-a * s0);
      e_i1[wr] = rnd(b * c1);  e_q1[wr] = rnd(-b * s1);
      macc = macc + (inc << 1) + 32'(carry_in);
    end else begin
      e_ok[wr] = k0;
      e_i0[wr] = rnd(a * c0 + b * s0);
      e_q0[wr] = rnd(b * c0 - a * s0);
      e_i1[wr] = 0; e_q1[wr] = 0;
      macc = macc + inc + 32'(carry_in);
    end
    e_pair[wr] = real_mode;
    e_cyc[wr]  = cyc;
    e_lat[wr]  = lat_on;
    e_tag[wr]  = tag;
    wr = (wr + 1) % QN;
  endtask

  // output monitor: compares every delivered beat in order (R7)
  always @(negedge clk) begin
    #7;
    if (rst_n && m_valid && m_ready) begin
      if (rd == wr) check(1'b0, "R7", "unexpected output beat", 1, 0);
      else begin
        check(m_pair == e_pair[rd], e_tag[rd], "m_pair", m_pair, e_pair[rd]);
        if (e_ok[rd]) begin
          check(m_i0 == e_i0[rd], e_tag[rd], "m_i0", m_i0, e_i0[rd]);
          check(m_q0 == e_q0[rd], e_tag[rd], "m_q0", m_q0, e_q0[rd]);
          check(m_i1 == e_i1[rd], e_tag[rd], "m_i1", m_i1, e_i1[rd]);
          check(m_q1 == e_q1[rd], e_tag[rd], "m_q1", m_q1, e_q1[rd]);
        end
        if (e_lat[rd])
          check(cyc - e_cyc[rd] == 4, "R6", "latency", cyc - e_cyc[rd], 4);
        rd = (rd + 1) % QN;
      end
    end
  end

  task automatic send(input int a, input int b, input bit mode, input bit cin,
                      input string tag);
    @(negedge clk);
    s_valid = 1'b1; s_a = DW'(a); s_b = DW'(b); real_mode = mode; carry_in = cin;
    forever begin
      #5;
      if (bp_on && m_valid && !m_ready)
        check(!s_ready, "R7", "s_ready while blocked", s_ready, 0);
      if (s_ready) begin
        push_beat(tag);
        break;
      end
      @(negedge clk);
    end
    @(posedge clk);
    #1 s_valid = 1'b0; carry_in = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #3;
    macc = '0; wr = 0; rd = 0;
    check(!m_valid, "R10", "m_valid in reset", m_valid, 0);
    check(s_ready, "R10", "s_ready in reset", s_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drain(input string tag, input int n);
    repeat (n) @(negedge clk);
    #9;
    check(rd == wr, tag, "beats outstanding", (wr - rd + QN) % QN, 0);
  endtask

  task automatic t_reset();
    do_reset();
  endtask

  task automatic t_cplx_grid();  // R1 R3 R5 R6 R8
    do_reset();
    freq_word = 32'h4000_0000; freq_adj = '0; lat_on = 1;
    send(1000, -2000, 0, 0, "R1,R3,R5,R8");
    send(-3000, 500, 0, 0, "R1,R3,R5,R8");
    send(32767, -32768, 0, 0, "R1,R3,R5,R8");
    send(-32768, 12345, 0, 0, "R1,R3,R5,R8");
    drain("R1", 10);
    lat_on = 0;
  endtask

  task automatic t_sat();  // R11
    do_reset();
    freq_word = 32'h2000_0000; freq_adj = '0;
    for (int k = 0; k < 8; k++) begin
      if (k % 2 == 0) send(32767, 32767, 0, 0, "R11,R5");
      else            send(-32768, -32768, 0, 0, "R11,R5");
    end
    drain("R11", 10);
  endtask

  task automatic t_real();  // R2
    do_reset();
    freq_word = 32'h4000_0000; freq_adj = '0;
    send(20000, -15000, 1, 0, "R2");
    send(-32768, 32767, 1, 0, "R2");
    send(7, -9, 1, 0, "R2");
    send(12000, 300, 0, 0, "R2,R8");
    send(-1234, 4321, 1, 0, "R2");
    drain("R2", 10);
  endtask

  task automatic t_carry();  // R4
    do_reset();
    freq_word = 32'h3FFF_FFFF; freq_adj = '0;
    send(20000, 0, 0, 1, "R4");
    send(20000, 0, 0, 0, "R4");
    drain("R4", 10);
  endtask

  task automatic t_adj();  // R9
    do_reset();
    freq_word = 32'h8000_0000; freq_adj = 32'hC000_0000;
    send(9000, 1000, 0, 0, "R9");
    send(9000, 1000, 0, 0, "R9");
    send(-500, 25000, 0, 0, "R9");
    send(4000, -4000, 1, 0, "R9");
    drain("R9", 10);
    freq_adj = '0;
  endtask

  task automatic t_backpressure();  // R7
    do_reset();
    freq_word = 32'h4000_0000; freq_adj = '0;
    bp_on = 1;
    for (int k = 0; k < 10; k++)
      send(1000 * k - 4000, 3000 - 700 * k, k % 3 == 1, 0, "R7");
    drain("R7", 40);
    bp_on = 0;
  endtask

  initial begin
    t_reset();
    t_cplx_grid();
    t_sat();
    t_real();
    t_carry();
    t_adj();
    t_backpressure();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (R7): actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule